// File: doc/BRIEF.md
# Burst Synchronous Serial Port with Byte Queue

This block moves a short burst of bytes over a clocked three-wire serial link without software attention between bytes. Software first fills an eight-entry byte queue through a simple write strobe and programs how many bytes the next burst carries (one to eight). A single start pulse then shifts those bytes out on the data output while capturing the same number of bytes from the data input. Each received byte overwrites the queue entry it was sent from, so once the burst ends the queue holds the received data in order and can be read back through the read strobe.

The port either drives the serial clock itself or follows a clock from an external master. Bit order can be most-significant-first or least-significant-first. An optional chip-select gate lets an external select line pause the transfer: while the select is inactive nothing shifts and the clock and data drivers are released. An optional strobe on the latch output marks the end of a burst, for example to update a shift-register display. A busy flag spans the whole burst and a done flag reports completion.

Top module: `burst_serial_port`

## Requirements
- R1: After reset the queue is empty and every entry reads as 0x00; `sck_out` and `so` are high, `lat`, `busy` and `done` are low.
- R2: While idle, each `wr_en` cycle stores `wr_data` in the next free queue entry, in order; once eight entries are filled further writes are discarded and do not alter any stored byte.
- R3: A `start` pulse while idle transfers `cnt_in+1` bytes (the 3-bit `cnt_in` field, written with `cnt_wr`, holds the byte count minus one), taken from queue entries 0 upward, with no gap in the serial clock between bytes.
- R4: With `lsb_first` = 0 each byte is sent and received bit 7 first; with `lsb_first` = 1 bit 0 first.
- R5: With `master` = 1 the port drives `sck_out`: it idles high, each bit is a low phase of 4 clocks followed by a high phase of 4 clocks, `so` changes only as `sck_out` falls.
- R6: `si` is sampled at each rising serial-clock edge; each received byte replaces the queue entry it was sent from, and after the burst `rd_data` shows entry 0 and each `rd_en` advances to the next entry.
- R7: With `master` = 0, `sck_oe` is low and shifting follows the falling and rising edges of `sck_in`.
- R8: With `cs_en` = 1, no serial clock edge occurs and no bit shifts while `cs_n` is high, and `sck_oe` and `so_oe` are low; the burst resumes where it paused once `cs_n` goes low.
- R9: With `latch_en` = 1, `lat` goes high after the last bit of the burst for exactly 8 clocks (one serial-clock period), and `done` rises as `lat` falls.
- R10: `busy` is high from the cycle after `start` until the burst, including any latch pulse, has ended; `done` is cleared by `start` and set at the end; they are never high together.
- R11: While `busy` is high, `wr_en` and `cnt_wr` have no effect on the queue or on the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Append `wr_data` to the queue (idle only) |
| wr_data | input | 8 | Byte to append |
| rd_en | input | 1 | Advance the read position (idle only) |
| rd_data | output | 8 | Queue entry at the read position |
| cnt_wr | input | 1 | Load `cnt_in` as the burst length (idle only) |
| cnt_in | input | 3 | Burst length minus one |
| lsb_first | input | 1 | 1 selects least-significant bit first |
| master | input | 1 | 1 drives the serial clock, 0 follows `sck_in` |
| cs_en | input | 1 | 1 gates shifting with `cs_n` |
| latch_en | input | 1 | 1 adds the end-of-burst strobe |
| start | input | 1 | Begin a burst (idle only) |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Driver enable for `sck_out` |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Driver enable for `so` |
| cs_n | input | 1 | Active-low select input |
| lat | output | 1 | End-of-burst latch strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |

## Verification
Checked on every cycle by properties: that `busy` and `done` never coincide, that the data output moves only on a falling serial-clock event, that the driven clock holds still while the select gate is closed, that the byte index never passes the programmed count, that `done` rises with the end of the latch strobe, and that queue writes are dropped while busy or full. Only the bench scenarios can show that the right bytes appear on the wire in the chosen bit order, that received bytes land in the right entries, that clock phases are four clocks wide, that the latch pulse lasts a full serial period, and that a paused burst resumes without losing a bit.

// File: rtl/sport_pkg.sv
// Shared types for the burst serial port.
package sport_pkg;

    // Burst sequencer states.
    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_SHIFT = 2'd1,
        SP_LATCH = 2'd2
    } sp_state_e;

    // Transfer configuration, frozen for the duration of a burst.
    typedef struct packed {
        logic lsb;
        logic master;
        logic cs_en;
        logic latch_en;
    } sp_cfg_t;

endpackage

// File: rtl/sport_fifo.sv
// Byte queue for the burst serial port.
// Software side: append at a write position, read at a read position; both
// are blocked while 'lock' is high. Burst side: one read address and one
// write address driven by the sequencer. 'rewind' returns both software
// positions to entry 0 at the end of a burst.
// Assumes the burst-side write is only used while 'lock' is high.
module sport_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    input  logic [AW-1:0] br_addr,
    output logic [W-1:0]  br_data,
    input  logic          bwr,
    input  logic [AW-1:0] bw_addr,
    input  logic [W-1:0]  bw_data,
    input  logic          rewind
);

    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW:0]   wp_q;
    logic [AW-1:0] rp_q;
    logic          full_w;

    assign full_w  = (wp_q == FULL_LVL);
    assign rd_data = mem_q[rp_q];
    assign br_data = mem_q[br_addr];

    // Storage: burst write has priority, software append only when idle and not full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (bwr) begin
            mem_q[bw_addr] <= bw_data;
        end else if (push && !lock && !full_w) begin
            mem_q[wp_q[AW-1:0]] <= push_data;
        end
    end

    // Positions: rewind at burst end, otherwise advance on accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (rewind) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (!lock) begin
            if (push && !full_w) wp_q <= wp_q + 1'b1;
            if (pop)             rp_q <= rp_q + 1'b1;
        end
    end

    // R11
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && push && !rewind) |=> (wp_q == $past(wp_q)));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && push && full_w) |=> (wp_q == $past(wp_q)));

endmodule

// File: rtl/sport_sckgen.sv
// Serial clock engine for the burst serial port.
// Master: a phase counter produces a clock that idles high, with HALF
// clocks low then HALF clocks high per bit. Slave: the external clock is
// synchronised and its edges detected. Both produce single-cycle fall and
// rise events. The select input is synchronised and, when gating is on,
// freezes the engine while inactive.
// Assumes the external clock half period is well above three system clocks.
module sport_sckgen #(
    parameter int HALF = 4,
    localparam int PW  = $clog2(2*HALF)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic master,
    input  logic cs_en,
    input  logic cs_n,
    input  logic sck_in,
    output logic fall_ev,
    output logic rise_ev,
    output logic sck_drv,
    output logic gate
);

    localparam logic [PW-1:0] RISE_PC = PW'(HALF);
    localparam logic [PW-1:0] LAST_PC = PW'(2*HALF-1);

    logic [PW-1:0] pc_q;
    logic          sck_q;
    logic          cs_s1_q, cs_s2_q;
    logic          sk_s1_q, sk_s2_q, sk_s3_q;
    logic          m_step;

    assign gate    = !cs_en || !cs_s2_q;
    assign m_step  = run && master && gate;
    assign sck_drv = sck_q;

    assign fall_ev = run && gate && (master ? (pc_q == '0)   : (sk_s3_q && !sk_s2_q));
    assign rise_ev = run && gate && (master ? (pc_q == RISE_PC) : (!sk_s3_q && sk_s2_q));

    // Two-stage synchroniser for the select input (idles inactive).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s1_q <= 1'b1;
            cs_s2_q <= 1'b1;
        end else begin
            cs_s1_q <= cs_n;
            cs_s2_q <= cs_s1_q;
        end
    end

    // Synchroniser plus edge history for the external serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_s1_q <= 1'b1;
            sk_s2_q <= 1'b1;
            sk_s3_q <= 1'b1;
        end else begin
            sk_s1_q <= sck_in;
            sk_s2_q <= sk_s1_q;
            sk_s3_q <= sk_s2_q;
        end
    end

    // Master phase counter: restarts at each burst, frozen while gated.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pc_q <= '0;
        end else if (m_step) begin
            pc_q <= (pc_q == LAST_PC) ? '0 : pc_q + 1'b1;
        end
    end

    // Driven clock level: low from phase 0, high from phase HALF, high when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck_q <= 1'b1;
        end else if (m_step) begin
            if (pc_q == '0)         sck_q <= 1'b0;
            else if (pc_q == RISE_PC) sck_q <= 1'b1;
        end
    end

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !gate) |=> (sck_q == $past(sck_q)));

endmodule

// File: rtl/sport_shifter.sv
// Bit shifter for the burst serial port.
// One register serves both directions: on a fall event the next outgoing
// bit is moved to the data output, on a rise event the input bit enters
// at the far end. After W rise events the register holds the received
// byte, presented on rx_byte together with byte_done.
// Assumes load and a fall event never coincide.
module sport_shifter #(
    parameter int W    = 8,
    localparam int BW  = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         lsb_first,
    input  logic         fall_ev,
    input  logic         rise_ev,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         si,
    output logic         so,
    output logic         byte_done,
    output logic [W-1:0] rx_byte
);

    logic [W-1:0]  sr_q;
    logic [BW-1:0] bcnt_q;
    logic          so_q;

    assign rx_byte   = lsb_first ? {si, sr_q[W-1:1]} : {sr_q[W-2:0], si};
    assign byte_done = rise_ev && (bcnt_q == BW'(W-1));
    assign so        = so_q;

    // Shift register and bit counter: load a new byte or take in one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sr_q   <= load_data;
            bcnt_q <= '0;
        end else if (rise_ev) begin
            sr_q   <= rx_byte;
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

    // Output bit: present the leading bit at each fall, idle high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            so_q <= 1'b1;
        end else if (fall_ev) begin
            so_q <= lsb_first ? sr_q[0] : sr_q[W-1];
        end
    end

    // R5
    so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (so_q != $past(so_q))) |-> $past(fall_ev));

endmodule

// File: rtl/burst_serial_port.sv
// Burst serial port top level.
// A sequencer takes a start pulse, freezes the configuration, walks the
// queue from entry 0 to the programmed count, writes each received byte
// back in place and optionally holds the latch strobe for one serial
// period before reporting done.
// Assumes configuration inputs are settled at least one clock before start.
module burst_serial_port
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int HALF   = 4,
    localparam int CW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cnt_wr,
    input  logic [CW-1:0]     cnt_in,
    input  logic              lsb_first,
    input  logic              master,
    input  logic              cs_en,
    input  logic              latch_en,
    input  logic              start,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              cs_n,
    output logic              lat,
    output logic              busy,
    output logic              done
);

    localparam int LAT_CYC = 2*HALF;
    localparam int LW      = $clog2(LAT_CYC);
    localparam logic [LW-1:0] LAT_LAST = LW'(LAT_CYC-1);

    sp_state_e         state_q;
    sp_cfg_t           cfg_q;
    logic [CW-1:0]     cnt_q, bidx_q, br_addr;
    logic [LW-1:0]     lcnt_q;
    logic              lat_q, done_q;
    logic              busy_w, run_w, last_byte, start_ok;
    logic              rewind_w, shift_load;
    logic              fall_ev, rise_ev, sck_drv, gate, byte_done, so_w;
    logic [DATA_W-1:0] rx_byte, br_data;

    assign busy_w     = (state_q != SP_IDLE);
    assign run_w      = (state_q == SP_SHIFT);
    assign last_byte  = (bidx_q == cnt_q);
    assign start_ok   = start && !busy_w;
    assign br_addr    = busy_w ? CW'(bidx_q + 1'b1) : '0;
    assign shift_load = start_ok || (run_w && byte_done && !last_byte);
    assign rewind_w   = (run_w && byte_done && last_byte && !cfg_q.latch_en)
                     || ((state_q == SP_LATCH) && (lcnt_q == LAT_LAST));

    assign sck_out = sck_drv;
    assign sck_oe  = cfg_q.master && gate;
    assign so      = so_w;
    assign so_oe   = gate;
    assign lat     = lat_q;
    assign busy    = busy_w;
    assign done    = done_q;

    // Configuration follows the inputs while idle and holds during a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{lsb: 1'b0, master: 1'b1, cs_en: 1'b0, latch_en: 1'b0};
        end else if (!busy_w) begin
            cfg_q <= '{lsb: lsb_first, master: master, cs_en: cs_en, latch_en: latch_en};
        end
    end

    // Burst length register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr && !busy_w) begin
            cnt_q <= cnt_in;
        end
    end

    // Burst sequencer: byte index, latch timer, strobe and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SP_IDLE;
            bidx_q  <= '0;
            lcnt_q  <= '0;
            lat_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SP_IDLE: begin
                    if (start) begin
                        state_q <= SP_SHIFT;
                        bidx_q  <= '0;
                        done_q  <= 1'b0;
                    end
                end
                SP_SHIFT: begin
                    if (byte_done) begin
                        if (last_byte) begin
                            bidx_q <= '0;
                            if (cfg_q.latch_en) begin
                                state_q <= SP_LATCH;
                                lat_q   <= 1'b1;
                                lcnt_q  <= '0;
                            end else begin
                                state_q <= SP_IDLE;
                                done_q  <= 1'b1;
                            end
                        end else begin
                            bidx_q <= bidx_q + 1'b1;
                        end
                    end
                end
                SP_LATCH: begin
                    if (lcnt_q == LAT_LAST) begin
                        state_q <= SP_IDLE;
                        lat_q   <= 1'b0;
                        done_q  <= 1'b1;
                    end else begin
                        lcnt_q <= lcnt_q + 1'b1;
                    end
                end
                default: state_q <= SP_IDLE;
            endcase
        end
    end

    sport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy_w),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (rd_en),
        .rd_data   (rd_data),
        .br_addr   (br_addr),
        .br_data   (br_data),
        .bwr       (run_w && byte_done),
        .bw_addr   (bidx_q),
        .bw_data   (rx_byte),
        .rewind    (rewind_w)
    );

    sport_sckgen #(.HALF(HALF)) u_sckgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .master  (cfg_q.master),
        .cs_en   (cfg_q.cs_en),
        .cs_n    (cs_n),
        .sck_in  (sck_in),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev),
        .sck_drv (sck_drv),
        .gate    (gate)
    );

    sport_shifter #(.W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .lsb_first (cfg_q.lsb),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .load      (shift_load),
        .load_data (br_data),
        .si        (si),
        .so        (so_w),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_w && done_q));

    // R9
    lat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lat_q) |-> done_q);

    // R3
    byte_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> (bidx_q <= cnt_q));

endmodule

// File: tb/test_burst_serial_port.sv
module test_burst_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0, cnt_wr = 0, start = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] cnt_in = 0;
    logic       lsb_first = 0, master = 1, cs_en = 0, latch_en = 0;
    logic       sck_in = 1, si = 1, cs_n = 1;
    logic [7:0] rd_data;
    logic       sck_out, sck_oe, so, so_oe, lat, busy, done;

    always #2 clk = ~clk;

    burst_serial_port i_burst_serial_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cnt_wr(cnt_wr), .cnt_in(cnt_in),
        .lsb_first(lsb_first), .master(master), .cs_en(cs_en),
        .latch_en(latch_en), .start(start), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so), .so_oe(so_oe),
        .cs_n(cs_n), .lat(lat), .busy(busy), .done(done)
    );

    int         n_chk = 0, n_fail = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    logic       si_bits[$];
    bit         tb_lsb = 0, tb_slave = 0, tb_skip_phase = 0, tb_active = 0;
    int         bytes_seen = 0, edge_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: samples between edges, pops the scoreboard queues.
    logic prev_sck = 1'b1, prev_lat = 1'b0;
    int   run_len = 0, bitpos = 0, lat_len = 0;
    bit   seen_low = 0;
    logic [7:0] cap = 0;
    wire  line_sck = tb_slave ? sck_in : sck_out;

    always @(negedge clk) begin
        if (rst_n) begin
            if (line_sck !== prev_sck) begin
                if (!tb_slave) edge_cnt++;
                if (tb_active && !tb_slave && !tb_skip_phase) begin
                    if (line_sck == 1'b1)  chk("R5 low phase width", run_len, 4);
                    else if (seen_low)     chk("R5 high phase width", run_len, 4);
                end
                if (line_sck == 1'b0) begin
                    seen_low = 1;
                    if (tb_active && si_bits.size() > 0) si = si_bits.pop_front();
                end else if (tb_active) begin
                    if (tb_lsb) cap[bitpos] = so; else cap[7-bitpos] = so;
                    bitpos++;
                    if (bitpos == 8) begin
                        bitpos = 0;
                        bytes_seen++;
                        if (exp_tx.size() > 0) chk("R4 tx byte on wire", cap, exp_tx.pop_front());
                        else chk("R3 extra byte on wire", 1, 0);
                    end
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            prev_sck = line_sck;
            if (!tb_active) begin seen_low = 0; bitpos = 0; end
            if (lat === 1'b1) lat_len++;
            else if (prev_lat === 1'b1) begin
                chk("R9 latch width", lat_len, 8);
                chk("R9 done at latch end", done, 1);
                lat_len = 0;
            end
            prev_lat = lat;
        end
    end

    task automatic load(input logic [7:0] d[9], input int k);
        for (int i = 0; i < k; i++) begin
            wr_en = 1; wr_data = d[i];
            tick(1);
        end
        wr_en = 0;
    endtask

    // Driver: configure, fill the scoreboard queues, pulse start.
    task automatic begin_burst(input int n, input bit lsb, input bit slv, input bit cse,
                               input bit lte, input logic [7:0] tx[9], input logic [7:0] rx[9],
                               input bit set_cnt);
        lsb_first = lsb; master = !slv; cs_en = cse; latch_en = lte;
        tb_lsb = lsb; tb_slave = slv;
        if (set_cnt) begin cnt_wr = 1; cnt_in = 3'(n-1); end
        tick(1);
        cnt_wr = 0;
        tick(2);
        for (int i = 0; i < n; i++) begin
            exp_tx.push_back(tx[i]);
            exp_rx.push_back(rx[i]);
            for (int b = 0; b < 8; b++) si_bits.push_back(lsb ? rx[i][b] : rx[i][7-b]);
        end
        bytes_seen = 0;
        tb_active = 1;
        start = 1;
        tick(1);
        start = 0;
        chk("R10 busy after start", busy, 1);
        chk("R10 done cleared by start", done, 0);
    endtask

    task automatic finish_burst(input int n);
        while (done !== 1'b1) tick(1);
        tick(2);
        tb_active = 0;
        chk("R3 byte count", bytes_seen, n);
        chk("R10 busy low at end", busy, 0);
        chk("R10 done high at end", done, 1);
    endtask

    task automatic readback(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R6 readback", rd_data, exp_rx.pop_front());
            rd_en = 1;
            tick(1);
            rd_en = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] t1[9] = '{8'hA5, 8'h3C, 8'hF0, 0, 0, 0, 0, 0, 0};
        logic [7:0] r1[9] = '{8'h12, 8'h34, 8'h56, 0, 0, 0, 0, 0, 0};
        logic [7:0] t2[9] = '{8'h81, 8'h7E, 8'h0F, 0, 0, 0, 0, 0, 0};
        logic [7:0] r2[9] = '{8'hC3, 8'h01, 8'h80, 0, 0, 0, 0, 0, 0};
        logic [7:0] t3[9] = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF, 8'h99};
        logic [7:0] r3[9] = '{8'hFE, 8'hDC, 8'hBA, 8'h98, 8'h76, 8'h54, 8'h32, 8'h10, 0};
        logic [7:0] t4[9] = '{8'hB2, 8'h4D, 0, 0, 0, 0, 0, 0, 0};
        logic [7:0] r4[9] = '{8'h5A, 8'hE7, 0, 0, 0, 0, 0, 0, 0};
        logic [7:0] t5[9] = '{8'h96, 8'h1E, 0, 0, 0, 0, 0, 0, 0};
        logic [7:0] r5[9] = '{8'h69, 8'hD2, 0, 0, 0, 0, 0, 0, 0};
        int ec;

        tick(4);
        rst_n = 1;
        tick(2);
        // R1 reset state
        chk("R1 sck_out idle", sck_out, 1);
        chk("R1 so idle", so, 1);
        chk("R1 lat idle", lat, 0);
        chk("R1 busy idle", busy, 0);
        chk("R1 done idle", done, 0);
        chk("R1 empty entry", rd_data, 0);

        // Master, MSB first, three bytes; writes during the burst must be dropped (R11)
        load(t1, 3);
        begin_burst(3, 0, 0, 0, 0, t1, r1, 1);
        tick(10);
        wr_en = 1; wr_data = 8'h77; cnt_wr = 1; cnt_in = 3'd0;
        tick(1);
        wr_en = 0; cnt_wr = 0;
        finish_burst(3);
        chk("R7 master drives clock", sck_oe, 1);
        readback(3);
        chk("R11 busy write dropped", rd_data, 0);

        // Same count reused (count write while busy ignored), R11
        load(t2, 3);
        begin_burst(3, 0, 0, 0, 0, t2, r2, 0);
        finish_burst(3);
        readback(3);

        // LSB first, eight bytes with a ninth write discarded (R2), latch strobe (R9)
        load(t3, 9);
        begin_burst(8, 1, 0, 0, 1, t3, r3, 1);
        finish_burst(8);
        chk("R2 eight bytes kept", bytes_seen, 8);
        readback(8);

        // Slave mode, MSB first (R7)
        load(t4, 2);
        begin_burst(2, 0, 1, 0, 0, t4, r4, 1);
        chk("R7 slave clock released", sck_oe, 0);
        for (int i = 0; i < 16; i++) begin
            sck_in = 0; tick(8);
            sck_in = 1; tick(8);
        end
        finish_burst(2);
        readback(2);

        // Chip-select gated master burst with a pause (R8)
        tb_skip_phase = 1;
        cs_n = 1;
        load(t5, 2);
        ec = edge_cnt;
        begin_burst(2, 1, 0, 1, 0, t5, r5, 1);
        tick(20);
        chk("R8 no edge while deselected", edge_cnt - ec, 0);
        chk("R8 sck released", sck_oe, 0);
        chk("R8 so released", so_oe, 0);
        chk("R8 still busy", busy, 1);
        cs_n = 0;
        tick(30);
        chk("R8 clock runs when selected", (edge_cnt != ec), 1);
        cs_n = 1;
        tick(4);
        ec = edge_cnt;
        tick(20);
        chk("R8 paused mid burst", edge_cnt - ec, 0);
        chk("R8 so released mid burst", so_oe, 0);
        cs_n = 0;
        finish_burst(2);
        readback(2);
        tb_skip_phase = 0;
        cs_en = 0;

        chk("R3 scoreboard drained", exp_tx.size(), 0);
        summary();
        $finish;
    end

endmodule